// File: doc/BRIEF.md
# Arbiter Delay PUF Linear-Model Emulator

This block is a cycle-based digital stand-in for a multiplexer-switch arbiter PUF, driven by the additive linear delay model. The model describes the chip as a set of signed per-stage delay differences plus one signed offset. That offset also covers the setup time of the arbiter. Software or a test harness loads these numbers through a simple write port. Once loaded, the block answers challenges with the one-bit response the modelled circuit would give.

An evaluation starts with a one-cycle start pulse, which captures the challenge. The switch chain crosses the two delay paths at every stage whose challenge bit is 1. Because of that, each stage weight is signed by the parity of its own challenge bit and every more significant bit, not by its own bit alone. The datapath walks the stages from the most significant end and keeps a running XOR. It adds one signed weight per clock, then adds the offset in a final cycle. The response is the sign of the total. A done pulse marks the result, and busy covers the whole evaluation.

Top module: `delay_puf_emu`

## Requirements
- R1: After reset, busy, done and response are all 0 and every stored weight is 0.
- R2: A write with wrEn high stores wrData (16-bit two's complement) at wrAddr. Addresses 0 to NUM_STAGES-1 select stage weights y0..y(n-1). Address NUM_STAGES selects the offset T. Any higher address is ignored.
- R3: Stage i contributes +y_i when the XOR of challenge bits i through n-1 is 0, and -y_i when it is 1.
- R4: The response is 1 when T plus the sum of the signed stage terms is strictly positive. It is 0 when that total is negative or exactly zero.
- R5: With start sampled high at clock edge E0 while idle, busy is high after E0 and stays high until edge E(n+1). After E(n+1), busy is 0 and done is 1 for exactly one cycle.
- R6: A start pulse while busy is ignored. The running evaluation keeps its challenge and its completion time.
- R7: A write while busy is ignored. A write in the same cycle as an accepted start is also ignored.
- R8: The response holds its value from one completed evaluation to the next. It does not change with the challenge input in between.
- R9: The accumulator does not overflow. Every weight at -32768 or at +32767 still yields the correct sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Weight write strobe |
| wrAddr | input | $clog2(NUM_STAGES+1) | Weight address (stage index, or NUM_STAGES for the offset) |
| wrData | input | WEIGHT_W | Signed weight value |
| start | input | 1 | Begin an evaluation (one-cycle pulse) |
| challenge | input | NUM_STAGES | Challenge bits, sampled with start |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when response is updated |
| response | output | 1 | Emulated arbiter decision |

## Verification
A start sampled at edge E0 produces done and a new response after edge E(n+1), which is 65 edges for the default width. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge, checks busy high and done low on each of the first n, and checks done high with busy low on the (n+1)th. The cycle after that must show done low again. Write and start disturbances are placed on chosen edges inside this window, and their effect is judged only from the response of that evaluation and of the next one.

// File: rtl/puf_emu_pkg.sv
package puf_emu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture challenge, clear accumulator
    logic step;    // fold one stage weight
    logic finish;  // fold offset, latch response
  } ctrlStrobe_t;
endpackage

// File: rtl/puf_emu_ctrl.sv
module puf_emu_ctrl
  import puf_emu_pkg::*;
#(
  parameter int NUM_STAGES = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  output ctrlStrobe_t                   strobe,
  output logic [$clog2(NUM_STAGES)-1:0] stageIdx,
  output logic                          busy,
  output logic                          done
);
  localparam int IDX_W = $clog2(NUM_STAGES);
  localparam int CNT_W = IDX_W + 2;

  ctrlState_t state;

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start;
    strobe.step   = (state == ST_RUN);
    strobe.finish = (state == ST_FINAL);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stageIdx <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            stageIdx <= IDX_W'(NUM_STAGES - 1);
          end
        end
        ST_RUN: begin
          if (stageIdx == '0) state <= ST_FINAL;
          else stageIdx <= stageIdx - 1'b1;
        end
        ST_FINAL: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // evaluation length checker
  logic [CNT_W-1:0] chkCycles;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkCycles <= '0;
    else if (strobe.load) chkCycles <= '0;
    else if (busy) chkCycles <= chkCycles + 1'b1;
  end

  assert_done_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chkCycles == CNT_W'(NUM_STAGES + 1)));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stageIdx != '0) |=>
      (state == ST_RUN && stageIdx == $past(stageIdx) - 1'b1));
endmodule

// File: rtl/puf_weight_bank.sv
module puf_weight_bank #(
  parameter int NUM_STAGES = 64,
  parameter int WEIGHT_W   = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [$clog2(NUM_STAGES+1)-1:0]  wrAddr,
  input  logic [WEIGHT_W-1:0]              wrData,
  input  logic                             lockWrite,
  input  logic [$clog2(NUM_STAGES)-1:0]    rdIdx,
  output logic [WEIGHT_W-1:0]              stageWeight,
  output logic [WEIGHT_W-1:0]              offsetWeight
);
  localparam int ADDR_W = $clog2(NUM_STAGES + 1);

  logic                wrOk;
  logic [WEIGHT_W-1:0] stageWords [NUM_STAGES];

  assign wrOk = wrEn && !lockWrite;

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageWords[gi] <= '0;
      else if (wrOk && wrAddr == ADDR_W'(gi)) stageWords[gi] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) offsetWeight <= '0;
    else if (wrOk && wrAddr == ADDR_W'(NUM_STAGES)) offsetWeight <= wrData;
  end

  assign stageWeight = stageWords[rdIdx];

  assert_locked_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockWrite |=> $stable(offsetWeight));
  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADDR_W'(NUM_STAGES)) |=> $stable(offsetWeight));
endmodule

// File: rtl/puf_emu_datapath.sv
module puf_emu_datapath
  import puf_emu_pkg::*;
#(
  parameter int NUM_STAGES = 64,
  parameter int WEIGHT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [NUM_STAGES-1:0] challenge,
  input  logic [WEIGHT_W-1:0]   stageWeight,
  input  logic [WEIGHT_W-1:0]   offsetWeight,
  output logic                  response
);
  localparam int ACC_W = WEIGHT_W + $clog2(NUM_STAGES + 1);
  localparam int EXT_W = ACC_W - WEIGHT_W;
  localparam logic signed [ACC_W:0] STAGE_LIMIT =
    (ACC_W + 1)'(NUM_STAGES) * (ACC_W + 1)'(2 ** (WEIGHT_W - 1));

  logic [NUM_STAGES-1:0] chalShift;
  logic                  parity;
  logic [ACC_W-1:0]      acc;
  logic                  parityNext;
  logic [ACC_W-1:0]      stageExt;
  logic [ACC_W-1:0]      stageTerm;
  logic [ACC_W-1:0]      finalSum;

  always_comb begin
    parityNext = parity ^ chalShift[NUM_STAGES-1];
    stageExt   = {{EXT_W{stageWeight[WEIGHT_W-1]}}, stageWeight};
    stageTerm  = parityNext ? (ACC_W'(0) - stageExt) : stageExt;
    finalSum   = acc + {{EXT_W{offsetWeight[WEIGHT_W-1]}}, offsetWeight};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chalShift <= '0;
      parity    <= 1'b0;
      acc       <= '0;
      response  <= 1'b0;
    end else if (strobe.load) begin
      chalShift <= challenge;
      parity    <= 1'b0;
      acc       <= '0;
    end else if (strobe.step) begin
      chalShift <= {chalShift[NUM_STAGES-2:0], 1'b0};
      parity    <= parityNext;
      acc       <= acc + stageTerm;
    end else if (strobe.finish) begin
      response  <= !finalSum[ACC_W-1] && (finalSum != '0);
    end
  end

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(response));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> ($signed({acc[ACC_W-1], acc}) <= STAGE_LIMIT &&
                       $signed({acc[ACC_W-1], acc}) >= -STAGE_LIMIT));
endmodule

// File: rtl/delay_puf_emu.sv
module delay_puf_emu
  import puf_emu_pkg::*;
#(
  parameter int NUM_STAGES = 64,
  parameter int WEIGHT_W   = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [$clog2(NUM_STAGES+1)-1:0] wrAddr,
  input  logic [WEIGHT_W-1:0]             wrData,
  input  logic                            start,
  input  logic [NUM_STAGES-1:0]           challenge,
  output logic                            busy,
  output logic                            done,
  output logic                            response
);
  localparam int IDX_W = $clog2(NUM_STAGES);

  ctrlStrobe_t         strobe;
  logic [IDX_W-1:0]    stageIdx;
  logic [WEIGHT_W-1:0] stageWeight;
  logic [WEIGHT_W-1:0] offsetWeight;
  logic                lockWrite;

  assign lockWrite = busy || start;

  puf_emu_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe),
    .stageIdx(stageIdx), .busy(busy), .done(done)
  );

  puf_weight_bank #(.NUM_STAGES(NUM_STAGES), .WEIGHT_W(WEIGHT_W)) u_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lockWrite(lockWrite), .rdIdx(stageIdx), .stageWeight(stageWeight),
    .offsetWeight(offsetWeight)
  );

  puf_emu_datapath #(.NUM_STAGES(NUM_STAGES), .WEIGHT_W(WEIGHT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .challenge(challenge),
    .stageWeight(stageWeight), .offsetWeight(offsetWeight), .response(response)
  );
endmodule

// File: tb/sim_delay_puf_emu.sv
module sim_delay_puf_emu;
  localparam int N  = 64;
  localparam int AW = $clog2(N + 1);
  localparam int NV = 11;

  // table: every stage weight +1, offset and challenge vary
  localparam logic [N-1:0] VEC_CHAL [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h1, 64'h1, 64'h1_0000_0000, 64'h1_0000_0000};
  localparam int VEC_OFFS [NV] = '{0, 0, 1, -1, 0, 65, 64, -62, -61, 2, 3};
  localparam bit VEC_EXP  [NV] = '{1, 0, 1, 0, 0, 1, 0, 0, 1, 0, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic start = 1'b0;
  logic [N-1:0] challenge = '0;
  logic busy, done, response;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int wModel [N+1];

  always #5 clk = ~clk;

  delay_puf_emu #(.NUM_STAGES(N), .WEIGHT_W(16)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .challenge(challenge), .busy(busy), .done(done), .response(response)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit modelResp(input logic [N-1:0] ch);
    int sum = 0;
    bit p = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      p ^= ch[i];
      sum += p ? -wModel[i] : wModel[i];
    end
    sum += wModel[N];
    return sum > 0;
  endfunction

  task automatic writeWord(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(addr); wrData = data[15:0];
    @(negedge clk);
    wrEn = 1'b0;
    if (addr <= N) wModel[addr] = int'($signed(data[15:0]));
  endtask

  // mode: 0 plain, 1 write with start, 2 write mid-run, 3 start mid-run
  task automatic runEval(input logic [N-1:0] ch, input int mode, output bit resp);
    bit timingOk = 1'b1;
    @(negedge clk);
    challenge = ch; start = 1'b1;
    if (mode == 1) begin wrEn = 1'b1; wrAddr = AW'(N); wrData = 16'd30000; end
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0;
    for (int k = 1; k <= N + 1; k++) begin
      if (mode == 2 && k == 3) begin wrEn = 1'b1; wrAddr = AW'(N); wrData = 16'd30000; end
      else wrEn = 1'b0;
      if (mode == 3 && k == 5) begin start = 1'b1; challenge = ~ch; end
      else start = 1'b0;
      @(negedge clk);
      if (k <= N && (done !== 1'b0 || busy !== 1'b1)) timingOk = 1'b0;
    end
    check(timingOk && done === 1'b1 && busy === 1'b0, "R5 done at n+1",
          {busy, done}, 2'b01);
    resp = response;
    challenge = ~challenge;
    @(negedge clk);
    check(done === 1'b0, "R5 done single pulse", done, 0);
    check(response === resp, "R8 response held", response, resp);
  endtask

  initial begin
    bit r;
    for (int i = 0; i <= N; i++) wModel[i] = 0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && response === 1'b0, "R1 reset outputs",
          {busy, done, response}, 0);
    rstN = 1'b1;
    runEval(64'hFFFF_0000_1234_5678, 0, r);
    check(r == 1'b0, "R1 zero weights give zero sum", r, 0);

    for (int i = 0; i < N; i++) writeWord(i, 1);
    for (int v = 0; v < NV; v++) begin
      writeWord(N, VEC_OFFS[v]);
      runEval(VEC_CHAL[v], 0, r);
      check(r == VEC_EXP[v], $sformatf("R3 R4 vector %0d", v), r, VEC_EXP[v]);
    end

    // R2 out-of-range address ignored (all ones, T=0 gives zero sum)
    writeWord(N, 0);
    writeWord(100, 30000);
    writeWord(127, -30000);
    runEval(64'hFFFF_FFFF_FFFF_FFFF, 0, r);
    check(r == 1'b0, "R2 high address ignored", r, 0);

    // R7 writes blocked while busy or with start
    runEval(64'hFFFF_FFFF_FFFF_FFFF, 1, r);
    check(r == 1'b0, "R7 write with start ignored", r, 0);
    runEval(64'hFFFF_FFFF_FFFF_FFFF, 2, r);
    check(r == 1'b0, "R7 write during busy ignored", r, 0);
    runEval(64'hFFFF_FFFF_FFFF_FFFF, 0, r);
    check(r == 1'b0, "R7 offset unchanged afterwards", r, 0);

    // R6 start while busy: challenge 0 gives 1, its inverse gives 0
    runEval(64'h0, 3, r);
    check(r == 1'b1, "R6 mid-run start ignored", r, 1);

    // R3 R4 mixed weights against model
    for (int i = 0; i <= N; i++) writeWord(i, ((i * 7919 + 13) % 2001) - 1000);
    for (int t = 0; t < 6; t++) begin
      logic [N-1:0] ch = {32'(t * 32'h9E37_79B9 + 32'h1234_5677), 32'(32'hDEAD_BEEF ^ (t * 32'h0101_0107))};
      bit e = modelResp(ch);
      runEval(ch, 0, r);
      check(r == e, $sformatf("R3 R4 mixed pattern %0d", t), r, e);
    end

    // R9 extreme weights
    for (int i = 0; i <= N; i++) writeWord(i, -32768);
    runEval(64'h0, 0, r);
    check(r == 1'b0, "R9 all min, straight", r, 0);
    runEval(64'h8000_0000_0000_0000, 0, r);
    check(r == 1'b1, "R9 all min, crossed", r, 1);
    for (int i = 0; i <= N; i++) writeWord(i, 32767);
    runEval(64'h0, 0, r);
    check(r == 1'b1, "R9 all max, straight", r, 1);
    runEval(64'h8000_0000_0000_0000, 0, r);
    check(r == 1'b0, "R9 all max, crossed", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule